// File: doc/BRIEF.md
# Page Write Buffer and Programming Sequencer

This block sits between the serial command engine of a byte-wide non-volatile memory and its storage array. After the command engine has received a target address, it presents each accepted data byte with a one-cycle strobe. The block stores the byte in a page buffer of `PAGE_BYTES` entries, marks that slot as entered, and advances only the in-page part of the address counter. Entry therefore wraps around inside the page and never spills into the next one.

When the command engine reports a STOP, the block may start a self-timed programming cycle. It does so only if at least one byte was entered, the hardware write-protect input is low and the target page is not locked. The cycle walks the page once and writes FFh to every entered slot, then waits `ERASE_CYC` clocks. It walks the page a second time and writes the buffered values, then waits `PROG_CYC` clocks. During the whole cycle `busy` is high, so the command engine can refuse new command bytes, and the block ignores address loads and data strobes. The address counter keeps its value across the cycle.

Top module: `page_prog_seq`

## Requirements
- R1: After reset, `busy` is 0, `mem_we` is 0 and `addr_cnt` is 0.
- R2: A pulse on `addr_load` sets `addr_cnt` to `addr_in`. Each `byte_vld` pulse while idle adds one to the low log2(PAGE_BYTES) bits of `addr_cnt` (bits 4..0 by default), modulo the page size. The upper page bits are unchanged.
- R3: Suppose `stop_stb` is sampled while idle, at least one byte has been entered since the last address load, restart or STOP, `wp_in` is 0 and `page_locked` is 0. Then `busy` is 1 from the next cycle for exactly 2*PAGE_BYTES + ERASE_CYC + PROG_CYC cycles.
- R4: In that cycle the erase pass issues exactly one write of FFh per entered slot, in ascending in-page offset, at address {page bits of `addr_cnt`, offset}. After it, the program pass issues one write per entered slot in the same order, carrying the last byte entered into that slot. No other writes occur.
- R5: Slots of the page that were not entered receive no write in either pass, and `mem_we` is never 1 while `busy` is 0.
- R6: While `busy` is 1, `addr_load` and `byte_vld` have no effect. After the cycle, `addr_cnt` holds the value it had when STOP was sampled.
- R7: With `wp_in` at 1 when STOP is sampled, data bytes still advance `addr_cnt`, but no cycle starts (`busy` stays 0) and no write is issued.
- R8: With `page_locked` at 1 when STOP is sampled, no cycle starts and no write is issued.
- R9: A STOP with no byte entered since the last `addr_load`, `restart_stb` or STOP starts no cycle. A `restart_stb` discards the entered bytes. Every STOP sampled while idle discards them as well, once any cycle it starts has finished.
- R10: If more than PAGE_BYTES bytes are entered, each later byte replaces the earlier one at the same wrapped offset, and only the last value per slot is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Load the address counter from `addr_in` |
| addr_in | input | AW | Address delivered by the command engine |
| byte_vld | input | 1 | One accepted data byte is on `byte_data` |
| byte_data | input | 8 | Data byte value |
| stop_stb | input | 1 | STOP condition seen on the bus |
| restart_stb | input | 1 | Repeated START seen; abandon the entry |
| wp_in | input | 1 | Hardware write protect, 1 = suppress programming |
| page_locked | input | 1 | Protection state of the addressed page, 1 = locked |
| busy | output | 1 | Programming cycle in progress |
| addr_cnt | output | AW | Current address counter |
| mem_we | output | 1 | Array write enable, sampled on the rising clock edge |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The assertions assume that the command engine pulses at most one of `addr_load`, `byte_vld`, `stop_stb` and `restart_stb` in any cycle. They also assume that `wp_in` and `page_locked` are settled in the cycle STOP is sampled. The stimulus drives every strobe as a single-cycle pulse from the falling clock edge and never overlaps two of them while idle. The only deliberate overlap is an address load and a data strobe given together while `busy` is high, which tests that both are ignored.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [2:0] {
    PS_IDLE  = 3'd0,
    PS_ERASE = 3'd1,
    PS_EHOLD = 3'd2,
    PS_PROG  = 3'd3,
    PS_PHOLD = 3'd4
  } pp_state_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/pp_addr_ctr.sv
module pp_addr_ctr #(
  parameter int AW = 12,
  parameter int OW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] cnt
);
  logic [AW-1:0] cnt_d;
  logic [OW-1:0] ofs_inc;

  assign ofs_inc = cnt[OW-1:0] + OW'(1);

  always_comb begin
    cnt_d = cnt;
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = {cnt[AW-1:OW], ofs_inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load || step) cnt <= cnt_d;
  end
endmodule

// File: rtl/pp_page_buf.sv
module pp_page_buf #(
  parameter int NB = 32,
  parameter int OW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [OW-1:0] wr_ofs,
  input  logic [7:0]    wr_data,
  input  logic          clr,
  input  logic [OW-1:0] rd_ofs,
  output logic [7:0]    rd_data,
  output logic [NB-1:0] mask,
  output logic          any
);
  logic [7:0] slot_q [NB];

  for (genvar s = 0; s < NB; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_ofs == OW'(s));

    always_ff @(posedge clk) begin
      if (hit) slot_q[s] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask[s] <= 1'b0;
      else if (clr)  mask[s] <= 1'b0;
      else if (hit)  mask[s] <= 1'b1;
    end
  end

  assign rd_data = slot_q[rd_ofs];
  assign any     = |mask;
endmodule

// File: rtl/pp_seq_fsm.sv
module pp_seq_fsm
  import pp_pkg::*;
#(
  parameter int NB        = 32,
  parameter int OW        = 5,
  parameter int ERASE_CYC = 20,
  parameter int PROG_CYC  = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          busy,
  output logic          erase_ph,
  output logic          prog_ph,
  output logic          done,
  output logic [OW-1:0] walk_ofs
);
  localparam int TMAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [OW-1:0] LAST_OFS = OW'(NB - 1);
  localparam logic [TW-1:0] E_END    = TW'(ERASE_CYC - 1);
  localparam logic [TW-1:0] P_END    = TW'(PROG_CYC - 1);

  pp_state_e     st_q, st_d;
  logic [OW-1:0] ofs_q, ofs_d;
  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    st_d  = st_q;
    ofs_d = ofs_q;
    tmr_d = tmr_q;
    done  = 1'b0;
    unique case (st_q)
      PS_IDLE: if (go) begin
        st_d  = PS_ERASE;
        ofs_d = '0;
      end
      PS_ERASE: begin
        ofs_d = ofs_q + OW'(1);
        if (ofs_q == LAST_OFS) begin
          st_d  = PS_EHOLD;
          tmr_d = '0;
        end
      end
      PS_EHOLD: begin
        tmr_d = tmr_q + TW'(1);
        if (tmr_q == E_END) begin
          st_d  = PS_PROG;
          ofs_d = '0;
        end
      end
      PS_PROG: begin
        ofs_d = ofs_q + OW'(1);
        if (ofs_q == LAST_OFS) begin
          st_d  = PS_PHOLD;
          tmr_d = '0;
        end
      end
      PS_PHOLD: begin
        tmr_d = tmr_q + TW'(1);
        if (tmr_q == P_END) begin
          st_d = PS_IDLE;
          done = 1'b1;
        end
      end
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      ofs_q <= '0;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      ofs_q <= ofs_d;
      tmr_q <= tmr_d;
    end
  end

  assign busy     = (st_q != PS_IDLE);
  assign erase_ph = (st_q == PS_ERASE);
  assign prog_ph  = (st_q == PS_PROG);
  assign walk_ofs = ofs_q;
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
  import pp_pkg::*;
#(
  parameter int AW         = 12,
  parameter int PAGE_BYTES = 32,
  parameter int ERASE_CYC  = 20,
  parameter int PROG_CYC   = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          byte_vld,
  input  logic [7:0]    byte_data,
  input  logic          stop_stb,
  input  logic          restart_stb,
  input  logic          wp_in,
  input  logic          page_locked,
  output logic          busy,
  output logic [AW-1:0] addr_cnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata
);
  localparam int OW = $clog2(PAGE_BYTES);

  logic [1:0]            rst_sync_q;
  logic                  rst_i;
  logic                  go, done, erase_ph, prog_ph;
  logic                  do_load, do_step, buf_clr, buf_any;
  logic [OW-1:0]         walk_ofs;
  logic [7:0]            rd_data;
  logic [PAGE_BYTES-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign do_load = addr_load & ~busy;
  assign do_step = byte_vld & ~busy;
  assign go      = stop_stb & ~busy & buf_any & ~wp_in & ~page_locked;
  assign buf_clr = done
                 | (~busy & (addr_load | restart_stb))
                 | (~busy & stop_stb & ~go);

  pp_addr_ctr #(.AW(AW), .OW(OW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_i),
    .load     (do_load),
    .load_val (addr_in),
    .step     (do_step),
    .cnt      (addr_cnt)
  );

  pp_page_buf #(.NB(PAGE_BYTES), .OW(OW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_i),
    .wr_en   (do_step),
    .wr_ofs  (addr_cnt[OW-1:0]),
    .wr_data (byte_data),
    .clr     (buf_clr),
    .rd_ofs  (walk_ofs),
    .rd_data (rd_data),
    .mask    (mask),
    .any     (buf_any)
  );

  pp_seq_fsm #(
    .NB(PAGE_BYTES), .OW(OW), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_i),
    .go       (go),
    .busy     (busy),
    .erase_ph (erase_ph),
    .prog_ph  (prog_ph),
    .done     (done),
    .walk_ofs (walk_ofs)
  );

  assign mem_we    = (erase_ph | prog_ph) & mask[walk_ofs];
  assign mem_addr  = {addr_cnt[AW-1:OW], walk_ofs};
  assign mem_wdata = erase_ph ? ERASED_BYTE : rd_data;
endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
  parameter int AW = 12,
  parameter int OW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_load,
  input logic          byte_vld,
  input logic          stop_stb,
  input logic          wp_in,
  input logic          page_locked,
  input logic          busy,
  input logic [AW-1:0] addr_cnt,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  a_r5_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r3_start_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_stb));

  a_r7_wp_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_in));

  a_r8_lock_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(page_locked));

  a_r2_page_bits_held: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !busy && !addr_load) |=>
      (addr_cnt[AW-1:OW] == $past(addr_cnt[AW-1:OW])));

  a_r6_counter_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_cnt));

  a_r4_write_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[AW-1:OW] == addr_cnt[AW-1:OW]));
endmodule

bind page_prog_seq pp_checker #(.AW(AW), .OW(OW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_load   (addr_load),
  .byte_vld    (byte_vld),
  .stop_stb    (stop_stb),
  .wp_in       (wp_in),
  .page_locked (page_locked),
  .busy        (busy),
  .addr_cnt    (addr_cnt),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr)
);

// File: tb/sim_page_prog_seq.sv
module sim_page_prog_seq;
  localparam int AW = 12;
  localparam int NB = 32;
  localparam int EC = 20;
  localparam int PC = 30;
  localparam int BUSY_LEN = 2 * NB + EC + PC;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [7:0]    d;
  } wr_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          addr_load, byte_vld, stop_stb, restart_stb, wp_in, page_locked;
  logic [AW-1:0] addr_in;
  logic [7:0]    byte_data;
  logic          busy, mem_we;
  logic [AW-1:0] addr_cnt, mem_addr;
  logic [7:0]    mem_wdata;

  int n_chk = 0;
  int n_fail = 0;
  wr_t exp_q[$];

  logic [AW-1:0] m_addr;
  logic [7:0]    m_buf [NB];
  logic          m_mask [NB];

  always #2.5 clk = ~clk;

  page_prog_seq #(.AW(AW), .PAGE_BYTES(NB), .ERASE_CYC(EC), .PROG_CYC(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_stb(stop_stb),
    .restart_stb(restart_stb), .wp_in(wp_in), .page_locked(page_locked),
    .busy(busy), .addr_cnt(addr_cnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Monitor: every write on the array port is popped and compared
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        check("R5 unexpected write addr", 32'(mem_addr), 32'hFFFF_FFFF);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        check("R4 write addr", 32'(mem_addr), 32'(e.a));
        check("R4 write data", 32'(mem_wdata), 32'(e.d));
      end
    end
  end

  task automatic m_clear();
    for (int i = 0; i < NB; i++) m_mask[i] = 1'b0;
  endtask

  task automatic pulse_load(input logic [AW-1:0] a);
    addr_in = a; addr_load = 1'b1;
    @(negedge clk); addr_load = 1'b0;
    m_addr = a; m_clear();
  endtask

  task automatic pulse_byte(input logic [7:0] d);
    byte_data = d; byte_vld = 1'b1;
    @(negedge clk); byte_vld = 1'b0;
    m_buf[m_addr[4:0]] = d; m_mask[m_addr[4:0]] = 1'b1;
    m_addr = {m_addr[AW-1:5], 5'(m_addr[4:0] + 5'd1)};
  endtask

  task automatic pulse_restart();
    restart_stb = 1'b1;
    @(negedge clk); restart_stb = 1'b0;
    m_clear();
  endtask

  // Driver: push the expected erase pass then the program pass
  task automatic push_cycle();
    for (int i = 0; i < NB; i++)
      if (m_mask[i]) exp_q.push_back('{a: {m_addr[AW-1:5], 5'(i)}, d: 8'hFF});
    for (int i = 0; i < NB; i++)
      if (m_mask[i]) exp_q.push_back('{a: {m_addr[AW-1:5], 5'(i)}, d: m_buf[i]});
  endtask

  // STOP that must start a cycle; measures busy and pokes ignored inputs
  task automatic stop_prog(input string tag);
    int n;
    logic [AW-1:0] held;
    held = addr_cnt;
    push_cycle();
    stop_stb = 1'b1;
    @(negedge clk); stop_stb = 1'b0;
    n = 0;
    while (busy && n < BUSY_LEN + 10) begin
      if (n == 3) begin addr_in = 12'h000; addr_load = 1'b1; byte_vld = 1'b1; byte_data = 8'h5A; end
      else begin addr_load = 1'b0; byte_vld = 1'b0; end
      n++;
      @(negedge clk);
    end
    addr_load = 1'b0; byte_vld = 1'b0;
    check({"R3 busy length ", tag}, 32'(n), 32'(BUSY_LEN));
    check({"R4 all writes seen ", tag}, 32'(exp_q.size()), 32'd0);
    check({"R6 counter kept ", tag}, 32'(addr_cnt), 32'(held));
    m_clear();
  endtask

  // STOP that must not start a cycle
  task automatic stop_none(input string req);
    int hi;
    stop_stb = 1'b1;
    @(negedge clk); stop_stb = 1'b0;
    hi = 0;
    for (int i = 0; i < 6; i++) begin
      if (busy) hi++;
      @(negedge clk);
    end
    check({req, " no cycle"}, 32'(hi), 32'd0);
    m_clear();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    addr_load = 0; byte_vld = 0; stop_stb = 0; restart_stb = 0;
    wp_in = 0; page_locked = 0; addr_in = '0; byte_data = '0;
    m_addr = '0; m_clear();
    for (int i = 0; i < NB; i++) m_buf[i] = 8'h00;
    repeat (4) @(negedge clk);
    check("R1 busy reset", 32'(busy), 32'd0);
    check("R1 we reset", 32'(mem_we), 32'd0);
    check("R1 addr reset", 32'(addr_cnt), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Three bytes inside a page
    pulse_load(12'h123);
    check("R2 load", 32'(addr_cnt), 32'h123);
    pulse_byte(8'hA1); pulse_byte(8'hB2); pulse_byte(8'hC3);
    check("R2 advance", 32'(addr_cnt), 32'h126);
    stop_prog("basic");

    // Wrap across the page border: offsets 30,31,0,1
    pulse_load(12'h7FE);
    pulse_byte(8'h11); pulse_byte(8'h22); pulse_byte(8'h33); pulse_byte(8'h44);
    check("R2 wrap in page", 32'(addr_cnt), 32'h7E2);
    stop_prog("wrap");

    // Write protect
    wp_in = 1'b1;
    pulse_load(12'h200);
    pulse_byte(8'h01); pulse_byte(8'h02);
    check("R7 counter advances", 32'(addr_cnt), 32'h202);
    stop_none("R7");
    wp_in = 1'b0;
    stop_none("R9 after discard");

    // Locked page
    page_locked = 1'b1;
    pulse_load(12'h340);
    pulse_byte(8'h77);
    stop_none("R8");
    page_locked = 1'b0;

    // STOP with nothing entered, and restart after address
    pulse_load(12'h0A0);
    stop_none("R9 empty");
    pulse_load(12'h0A0);
    pulse_byte(8'h99);
    pulse_restart();
    check("R9 restart keeps addr", 32'(addr_cnt), 32'h0A1);
    stop_none("R9 restart");

    // Overflow: 34 bytes from offset 30
    pulse_load(12'h41E);
    for (int i = 0; i < 34; i++) pulse_byte(8'(i));
    check("R10 addr after 34", 32'(addr_cnt), 32'h400);
    check("R10 model slot30", 32'(m_buf[30]), 32'd32);
    stop_prog("R10 overflow");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule